// File: doc/BRIEF.md
# Command-Driven Serial EEPROM Byte Engine

This block is a two-wire serial bus master, run one primitive at a time by a processor. Software writes a 4-bit command code and, for transmissions, a data byte. The block then performs exactly one bus primitive: a start condition, a stop condition, a byte sent with the slave's acknowledge sampled, or a byte received with or without an acknowledge. Software builds every EEPROM transaction out of these primitives. The block makes no choices of its own about addressing or ordering.

A status byte reports the outcome of each primitive. It holds an error flag, a busy flag and two active-low acknowledge flags, with the last accepted command code in its low nibble. The serial clock comes from a parameterised divider. Each SCK period is split into four equal quarter phases. Data moves in the middle of the low phase. Start and stop move SDA in the middle of the high phase. Once any bus command has been issued, the clock keeps running until software writes the no-op code, which freezes it. SDA is open-drain: the block only pulls the line low, and it reads the line back through a separate input.

Top module: `eebus_engine`

## Requirements
- R1: After reset the status byte reads 0x30. This means ERROR (bit 7) = 0, BUSY (bit 6) = 0, RX_ACK (bit 5) = 1, TX_ACK (bit 4) = 1 and the command field (bits 3:0) = 0. SCK is high and SDA is released (`sda_oe` = 0).
- R2: Code 9 produces a start condition: SDA falls while SCK is high. It also works as a repeated start.
- R3: Code 5 produces a stop condition: SDA rises while SCK is high.
- R4: Code 3 sends `wdata` MSB first, one bit per SCK rising edge, then releases SDA for a ninth clock. During that clock it samples the slave's acknowledge into RX_ACK (bit 5), where 0 means acknowledged.
- R5: Code 2 receives eight bits MSB first on SCK rising edges and presents them on `rdata` once the eighth bit is sampled. It then pulls SDA low for the ninth clock, and TX_ACK (bit 4) reads 0.
- R6: Code 6 receives a byte as in R5 but leaves SDA released for the ninth clock (NACK), and TX_ACK reads 1.
- R7: Code 0 stops SCK, which then holds its level. Any bus command restarts it. Until a no-op arrives, SCK toggles continuously, even between commands.
- R8: Codes other than 0, 2, 3, 5, 6 and 9 cause no bus activity and set ERROR. ERROR stays set until the next accepted command write clears it.
- R9: BUSY rises on acceptance of a bus command and falls when the primitive's last SCK event completes. A write while BUSY is high is ignored: the command field, ERROR and the ongoing transfer are unaffected.
- R10: Outside a start or stop primitive, SDA changes only while SCK is low.
- R11: While running, each SCK half period lasts 2*QDIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_in | input | 4 | Command code |
| wdata | input | DW | Byte to transmit (code 3) |
| status | output | 8 | {ERROR, BUSY, RX_ACK, TX_ACK, command[3:0]} |
| rdata | output | DW | Last received byte |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The two functions that can meet in one cycle are command decode and the running byte engine. A processor write can land while a byte is halfway onto the wire. The bench provokes this by writing an undefined code about forty cycles into a transmit. It then judges that ERROR stays 0, that the command field still reads 3, and that the byte and acknowledge observed on the bus are exactly those of the original transmit. A second collision occurs when the no-op's clock freeze coincides with a divider tick. This is judged by SCK holding its level over a long idle window.

// File: rtl/eebus_pkg.sv
package eebus_pkg;

    localparam logic [3:0] OP_NOP    = 4'd0;
    localparam logic [3:0] OP_RDACK  = 4'd2;
    localparam logic [3:0] OP_WRITE  = 4'd3;
    localparam logic [3:0] OP_STOP   = 4'd5;
    localparam logic [3:0] OP_RDLAST = 4'd6;
    localparam logic [3:0] OP_START  = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_START,
        ST_STOP,
        ST_TXBIT,
        ST_TXACK,
        ST_RXBIT,
        ST_RXACK
    } seq_e;

    function automatic logic is_bus_op(input logic [3:0] c);
        return (c == OP_RDACK) || (c == OP_WRITE) || (c == OP_STOP) ||
               (c == OP_RDLAST) || (c == OP_START);
    endfunction

    function automatic seq_e first_state(input logic [3:0] c);
        case (c)
            OP_START: return ST_START;
            OP_STOP:  return ST_STOP;
            OP_WRITE: return ST_TXBIT;
            default:  return ST_RXBIT;
        endcase
    endfunction

endpackage

// File: rtl/eebus_qtick.sv
module eebus_qtick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (en) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eebus_shreg.sv
module eebus_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (load)       q_d = ld_val;
        else if (shift) q_d = {q_q[W-2:0], sin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/eebus_engine.sv
module eebus_engine
    import eebus_pkg::*;
#(
    parameter int QDIV = 4,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [3:0]    cmd_in,
    input  logic [DW-1:0] wdata,
    output logic [7:0]    status,
    output logic [DW-1:0] rdata,
    output logic          scl_o,
    output logic          sda_oe,
    input  logic          sda_i
);
    localparam int BW = $clog2(DW + 1);
    localparam logic [BW-1:0] LASTBIT = BW'(DW - 1);
    localparam logic [BW-1:0] FULL    = BW'(DW);

    typedef struct packed {
        seq_e          st;
        logic [3:0]    cmd;
        logic [BW-1:0] bitn;
        logic [1:0]    ph;
        logic          run;
        logic          scl;
        logic          oe;
        logic          err;
        logic          busy;
        logic          rxa_n;
        logic          txa_n;
        logic [DW-1:0] rd;
    } eng_s;

    eng_s q, n;

    logic          tick;
    logic [1:0]    nph;
    logic          ev_rise, ev_mhi, ev_fall, ev_mlo;
    logic          sh_load, sh_shift, sh_sin;
    logic [DW-1:0] sh_q;

    eebus_qtick #(.QDIV(QDIV)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (q.run),
        .tick (tick)
    );

    eebus_shreg #(.W(DW)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .ld_val(wdata),
        .shift (sh_shift),
        .sin   (sh_sin),
        .q     (sh_q)
    );

    always_comb begin
        n        = q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_sin   = 1'b0;

        // quarter phases: 0 rise, 1 mid-high, 2 fall, 3 mid-low
        nph     = q.ph + 2'd1;
        ev_rise = tick && (nph == 2'd0);
        ev_mhi  = tick && (nph == 2'd1);
        ev_fall = tick && (nph == 2'd2);
        ev_mlo  = tick && (nph == 2'd3);

        if (tick) n.ph = nph;
        if (ev_rise) n.scl = 1'b1;
        if (ev_fall) n.scl = 1'b0;

        case (q.st)
            ST_ALIGN: begin
                if (ev_fall) n.st = first_state(q.cmd);
            end
            ST_START: begin
                if (ev_mlo) n.oe = 1'b0;
                if (ev_mhi) n.oe = 1'b1;
                if (ev_fall) begin
                    n.busy = 1'b0;
                    n.st   = ST_IDLE;
                end
            end
            ST_STOP: begin
                if (ev_mlo) n.oe = 1'b1;
                if (ev_mhi) begin
                    n.oe   = 1'b0;
                    n.busy = 1'b0;
                    n.st   = ST_IDLE;
                end
            end
            ST_TXBIT: begin
                if (ev_mlo) n.oe = ~sh_q[DW-1];
                if (ev_fall) begin
                    sh_shift = 1'b1;
                    n.bitn   = q.bitn + 1'b1;
                    if (q.bitn == LASTBIT) n.st = ST_TXACK;
                end
            end
            ST_TXACK: begin
                if (ev_mlo) n.oe = 1'b0;
                if (ev_mhi) n.rxa_n = sda_i;
                if (ev_fall) begin
                    n.busy = 1'b0;
                    n.st   = ST_IDLE;
                end
            end
            ST_RXBIT: begin
                if (ev_mlo) n.oe = 1'b0;
                if (ev_mhi) begin
                    sh_shift = 1'b1;
                    sh_sin   = sda_i;
                    n.bitn   = q.bitn + 1'b1;
                    if (q.bitn == LASTBIT) n.rd = {sh_q[DW-2:0], sda_i};
                end
                if (ev_fall && (q.bitn == FULL)) n.st = ST_RXACK;
            end
            ST_RXACK: begin
                if (ev_mlo) n.oe = (q.cmd == OP_RDACK);
                if (ev_mhi) n.txa_n = (q.cmd != OP_RDACK);
                if (ev_fall) begin
                    n.busy = 1'b0;
                    n.st   = ST_IDLE;
                end
            end
            default: ;
        endcase

        if (cmd_we && !q.busy) begin
            n.cmd = cmd_in;
            n.err = 1'b0;
            if (cmd_in == OP_NOP) begin
                n.run = 1'b0;
            end else if (is_bus_op(cmd_in)) begin
                n.run   = 1'b1;
                n.busy  = 1'b1;
                n.st    = ST_ALIGN;
                n.bitn  = '0;
                sh_load = (cmd_in == OP_WRITE);
            end else begin
                n.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cmd   <= OP_NOP;
            q.bitn  <= '0;
            q.ph    <= 2'd1;
            q.run   <= 1'b0;
            q.scl   <= 1'b1;
            q.oe    <= 1'b0;
            q.err   <= 1'b0;
            q.busy  <= 1'b0;
            q.rxa_n <= 1'b1;
            q.txa_n <= 1'b1;
            q.rd    <= '0;
        end else begin
            q <= n;
        end
    end

    assign status = {q.err, q.busy, q.rxa_n, q.txa_n, q.cmd};
    assign rdata  = q.rd;
    assign scl_o  = q.scl;
    assign sda_oe = q.oe;
endmodule

// File: rtl/eebus_engine_chk.sv
module eebus_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [3:0] cmd_in,
    input logic [7:0] status,
    input logic       scl_o,
    input logic       sda_oe
);
    import eebus_pkg::*;

    logic in_edge_op;
    assign in_edge_op = status[6] && ((status[3:0] == OP_START) || (status[3:0] == OP_STOP));

    assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && !$past(in_edge_op)) |-> $stable(sda_oe));

    assert_write_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && status[6]) |=> ($stable(status[3:0]) && $stable(status[7])));

    assert_bad_code_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !status[6] && !is_bus_op(cmd_in) && (cmd_in != OP_NOP))
        |=> (status[7] && !status[6]));

    assert_clock_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[3:0] == OP_NOP) && !status[6] && $past((status[3:0] == OP_NOP) && !status[6]))
        |-> $stable(scl_o));

    assert_half_period_min_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o != $past(scl_o)) |=> $stable(scl_o));
endmodule

bind eebus_engine eebus_engine_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_we(cmd_we),
    .cmd_in(cmd_in),
    .status(status),
    .scl_o (scl_o),
    .sda_oe(sda_oe)
);

// File: tb/eebus_engine_tb.sv
`timescale 1ns/1ps
module eebus_engine_tb;
    localparam int QDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd_in = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] status;
    logic [7:0] rdata;
    logic       scl_o, sda_oe, sda_i;

    int         n_run = 0;
    int         n_fail = 0;
    int         slv_n = 0;
    logic [8:0] slv_vec = 9'd0;
    logic       slv_pull;
    logic [8:0] mon_bits = 9'd0;
    int         start_cnt = 0;
    int         stop_cnt = 0;

    localparam int K_TX = 0, K_RX = 1, K_STA = 2, K_STP = 3;
    typedef struct {
        int         kind;
        string      req;
        logic [7:0] b;
        logic       ack;
        int         cnt;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    assign slv_pull = (slv_n >= 1 && slv_n <= 9) ? slv_vec[9 - slv_n] : 1'b0;
    assign sda_i    = ~sda_oe & ~slv_pull;

    eebus_engine #(.QDIV(QDIV), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_in(cmd_in), .wdata(wdata),
        .status(status), .rdata(rdata), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    always @(negedge scl_o) slv_n = slv_n + 1;
    always @(posedge scl_o) mon_bits = {mon_bits[7:0], sda_i};
    always @(negedge sda_i) if (scl_o) start_cnt++;
    always @(posedge sda_i) if (scl_o) stop_cnt++;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] c, input logic [7:0] d, input logic [8:0] vec);
        slv_vec = vec;
        @(negedge clk);
        cmd_we = 1'b1; cmd_in = c; wdata = d;
        @(posedge clk);
        #1;
        cmd_we = 1'b0;
        slv_n  = 0;
    endtask

    task automatic push(input int k, input string req, input logic [7:0] b, input logic ack, input int cnt);
        exp_t e;
        e.kind = k; e.req = req; e.b = b; e.ack = ack; e.cnt = cnt;
        sb.push_back(e);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (status[6]) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_start();
        send(4'd9, 8'h00, 9'd0);
        push(K_STA, "R2", 8'h00, 1'b0, start_cnt + 1);
        wait_done();
    endtask

    task automatic do_stop();
        send(4'd5, 8'h00, 9'd0);
        push(K_STP, "R3", 8'h00, 1'b0, stop_cnt + 1);
        wait_done();
    endtask

    task automatic do_tx(input logic [7:0] b, input logic ack);
        send(4'd3, b, {8'h00, ack});
        push(K_TX, "R4", b, ack, 0);
        wait_done();
    endtask

    task automatic do_rx(input logic [7:0] b, input logic ack);
        send(ack ? 4'd2 : 4'd6, 8'h00, {~b, 1'b0});
        push(K_RX, ack ? "R5" : "R6", b, ack, 0);
        wait_done();
    endtask

    // scoreboard monitor: judges each primitive when BUSY falls
    initial begin
        exp_t e;
        forever begin
            @(negedge status[6]);
            #1;
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected completion", 0, 1);
            end else begin
                e = sb.pop_front();
                case (e.kind)
                    K_TX: begin
                        chk(mon_bits[8:1] == e.b, e.req, "byte on bus", mon_bits[8:1], e.b);
                        chk(mon_bits[0] == ~e.ack, e.req, "ack bit on bus", mon_bits[0], ~e.ack);
                        chk(status[5] == ~e.ack, e.req, "RX_ACK flag", status[5], ~e.ack);
                    end
                    K_RX: begin
                        chk(rdata == e.b, e.req, "rdata", rdata, e.b);
                        chk(mon_bits[0] == ~e.ack, e.req, "ack slot level", mon_bits[0], ~e.ack);
                        chk(status[4] == ~e.ack, e.req, "TX_ACK flag", status[4], ~e.ack);
                    end
                    K_STA: chk(start_cnt == e.cnt, e.req, "start count", start_cnt, e.cnt);
                    default: chk(stop_cnt == e.cnt, e.req, "stop count", stop_cnt, e.cnt);
                endcase
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int toggles;
        int hi;
        logic s0;
        logic oe0;
        int sc0, pc0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'h30, "R1", "status after reset", status, 8'h30);
        chk(scl_o == 1'b1, "R1", "scl after reset", scl_o, 1);
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);

        // R7 clock idle until first bus command
        toggles = 0; s0 = scl_o;
        repeat (50) begin @(negedge clk); if (scl_o != s0) toggles++; s0 = scl_o; end
        chk(toggles == 0, "R7", "scl toggles before first command", toggles, 0);

        // main sequence
        do_start();
        do_tx(8'hA5, 1'b1);
        do_tx(8'h3C, 1'b0);
        do_start();                 // repeated start
        do_tx(8'h81, 1'b1);
        do_rx(8'h5A, 1'b1);
        do_rx(8'h96, 1'b1);
        do_rx(8'hC3, 1'b0);
        do_stop();

        // R11 half period while running (clock not yet frozen)
        @(posedge scl_o);
        hi = 0;
        do begin @(posedge clk); #1; hi++; end while (scl_o);
        chk(hi == 2 * QDIV, "R11", "scl high time", hi, 2 * QDIV);
        toggles = 0; s0 = scl_o;
        repeat (64) begin @(negedge clk); if (scl_o != s0) toggles++; s0 = scl_o; end
        chk(toggles >= 6, "R7", "scl keeps toggling while idle", toggles, 8);

        // R8 undefined code
        oe0 = sda_oe; sc0 = start_cnt; pc0 = stop_cnt;
        send(4'd7, 8'h00, 9'd0);
        @(negedge clk);
        chk(status[7] == 1'b1, "R8", "ERROR set", status[7], 1);
        chk(status[6] == 1'b0, "R8", "BUSY stays low", status[6], 0);
        chk(status[3:0] == 4'd7, "R8", "command field", status[3:0], 7);
        repeat (40) @(negedge clk);
        chk(sda_oe == oe0 && start_cnt == sc0 && stop_cnt == pc0, "R8", "no bus activity",
            {sda_oe, 8'(start_cnt - sc0), 8'(stop_cnt - pc0)}, {oe0, 16'h0});
        chk(status[7] == 1'b1, "R8", "ERROR sticky", status[7], 1);
        send(4'd9, 8'h00, 9'd0);
        push(K_STA, "R2", 8'h00, 1'b0, start_cnt + 1);
        chk(status[7] == 1'b0, "R8", "ERROR cleared by next write", status[7], 0);
        chk(status[6] == 1'b1, "R9", "BUSY on acceptance", status[6], 1);
        wait_done();

        // R9 write during a transfer is ignored
        send(4'd3, 8'h69, 9'd1);
        push(K_TX, "R9", 8'h69, 1'b1, 0);
        repeat (40) @(negedge clk);
        cmd_we = 1'b1; cmd_in = 4'hF; wdata = 8'hFF;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(status[7] == 1'b0, "R9", "ERROR untouched by busy write", status[7], 0);
        chk(status[3:0] == 4'd3, "R9", "command field kept", status[3:0], 3);
        chk(status[6] == 1'b1, "R9", "still busy", status[6], 1);
        wait_done();
        do_stop();

        // R7 no-op freezes the clock, bus command restarts it
        send(4'd0, 8'h00, 9'd0);
        chk(status[3:0] == 4'd0 && status[7] == 1'b0, "R7", "no-op accepted", status, 8'h00);
        repeat (3) @(negedge clk);
        toggles = 0; s0 = scl_o;
        repeat (100) begin @(negedge clk); if (scl_o != s0) toggles++; s0 = scl_o; end
        chk(toggles == 0, "R7", "scl frozen after no-op", toggles, 0);
        do_start();
        do_tx(8'hF0, 1'b1);
        do_stop();

        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R9", "all primitives completed", sb.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule